// File: doc/BRIEF.md
# Five-Port Wormhole Mesh Router

This block is one switching node of a two-dimensional mesh network-on-chip. It has five bidirectional ports. Four of them face the neighbouring routers to the east, west, north and south, and the fifth faces the local processing core. Every input owns a small flit queue. A flit is accepted with a per-flit request/acknowledge handshake, and it leaves the same way. The router reads the header flit at the front of each queue and derives an output port from the target coordinates. Dimension-ordered routing is used, with X resolved before Y.

A round-robin arbiter opens at most one new connection per cycle. An open connection carries the header first, then a length flit, then the stated number of payload flits. None of these flits is routed again. The output is released when the last of them is taken downstream, and only then can another input win that output. The flit width, the queue depth and the router's own coordinates are parameters. An 8-bit build uses the same header layout, scaled down.

Top module: `mesh_router`

## Requirements
- R1: After reset every out_req is low, every input queue is empty, and the arbiter pointer stands at port 0.
- R2: in_ack[p] is high in a cycle exactly when in_req[p] is high and queue p holds fewer than QDEPTH flits. Such a flit is stored. While the queue holds QDEPTH flits, in_ack stays low.
- R3: The flits of an input leave in the order they arrived, with none lost and none duplicated.
- R4: Port indices are east 0, west 1, north 2, south 3 and local 4. The target field is the lower FLIT_W/2 bits of the header. Its upper half is X and its lower half is Y; the upper FLIT_W/2 header bits are the source tag. X is compared with MY_X first: a larger X goes east and a smaller X goes west. Only when X is equal is Y compared: a larger Y goes north and a smaller Y goes south.
- R5: A header whose X and Y both equal MY_X and MY_Y goes to the local port.
- R6: Once an output is granted, it carries the header, the length flit and the payload flits of that one packet, in order. No flit of any other input appears on it until it is released.
- R7: The second flit of a packet gives the payload count N. The output is released when its (N+2)-th flit is accepted downstream, or after the length flit when N is 0. It is then free for another packet.
- R8: While out_req[o] is high and out_ack[o] is low, out_req[o] stays high and out_flit[o] stays unchanged in the next cycle.
- R9: Contention is resolved round-robin over the five inputs. The search starts at the pointer, and after each grant the pointer moves to the input after the granted one.
- R10: At most one connection is opened per cycle. Two headers that wait for two different free outputs start on consecutive cycles.
- R11: With FLIT_W = 8 the same packet format and routing rules apply, using a 4-bit target field made of 2-bit X and 2-bit Y.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| in_req | input | 5 | A flit is offered on each input |
| in_flit | input | 5 x FLIT_W | Flit offered on each input |
| in_ack | output | 5 | The offered flit is taken this cycle |
| out_req | output | 5 | A flit is presented on each output |
| out_flit | output | 5 x FLIT_W | Flit presented on each output |
| out_ack | input | 5 | The downstream node takes the presented flit |

## Verification
The main instance uses 16-bit flits, a queue depth of 4 and coordinates (2,2). This lets every one of the five output directions be reached. The shallow queue fills after only four flits when an output is blocked, so the withheld acknowledge and the held output flit both show up within a short run. A second instance uses 8-bit flits, a depth of 2 and coordinates (1,1), and sends a packet south to confirm the narrow header split. Stalled downstream acknowledges are applied on a rotating pattern, so connections stay open across idle cycles while other inputs wait on the same outputs.

// File: rtl/mesh_router_pkg.sv
package mesh_router_pkg;
  localparam int NP = 5;
  localparam logic [2:0] P_EAST  = 3'd0;
  localparam logic [2:0] P_WEST  = 3'd1;
  localparam logic [2:0] P_NORTH = 3'd2;
  localparam logic [2:0] P_SOUTH = 3'd3;
  localparam logic [2:0] P_LOCAL = 3'd4;

  typedef enum logic [1:0] {PH_HEAD, PH_SIZE, PH_BODY} phase_e;

  // R4 R5: X first, then Y, local when both match
  function automatic logic [2:0] xy_route(input logic [7:0] tx, input logic [7:0] ty,
                                          input logic [7:0] mx, input logic [7:0] my);
    if (tx > mx) return P_EAST;
    if (tx < mx) return P_WEST;
    if (ty > my) return P_NORTH;
    if (ty < my) return P_SOUTH;
    return P_LOCAL;
  endfunction
endpackage

// File: rtl/flit_fifo.sv
module flit_fifo #(
  parameter int W     = 16,
  parameter int DEPTH = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         push,
  input  logic         pop,
  input  logic [W-1:0] din,
  output logic [W-1:0] dout,
  output logic         empty,
  output logic         full
);
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CW = $clog2(DEPTH + 1);

  logic [W-1:0]  mem [DEPTH];
  logic [AW-1:0] rd, wr;
  logic [CW-1:0] cnt;

  assign empty = (cnt == '0);
  assign full  = (cnt == CW'(DEPTH));
  assign dout  = mem[rd];

  always_ff @(posedge clk) begin
    if (push) mem[wr] <= din;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rd  <= '0;
      wr  <= '0;
      cnt <= '0;
    end else begin
      if (push) wr <= (wr == AW'(DEPTH - 1)) ? '0 : wr + 1'b1;
      if (pop)  rd <= (rd == AW'(DEPTH - 1)) ? '0 : rd + 1'b1;
      case ({push, pop})
        2'b10:   cnt <= cnt + 1'b1;
        2'b01:   cnt <= cnt - 1'b1;
        default: cnt <= cnt;
      endcase
    end
  end
endmodule

// File: rtl/rr_arb.sv
module rr_arb #(
  parameter int N = 5
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] req,
  output logic [N-1:0] grant
);
  localparam int PW = $clog2(N);
  logic [PW-1:0] ptr;

  // R9: first requester at or after the pointer
  always_comb begin
    int  idx;
    logic found;
    grant = '0;
    found = 1'b0;
    for (int k = 0; k < N; k++) begin
      idx = (int'(ptr) + k) % N;
      if (!found && req[idx]) begin
        grant[idx] = 1'b1;
        found      = 1'b1;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) ptr <= '0;
    else begin
      for (int j = 0; j < N; j++)
        if (grant[j]) ptr <= (j == N - 1) ? '0 : PW'(j + 1);
    end
  end
endmodule

// File: rtl/mesh_router.sv
module mesh_router
  import mesh_router_pkg::*;
#(
  parameter int FLIT_W = 16,
  parameter int QDEPTH = 8,
  parameter int MY_X   = 1,
  parameter int MY_Y   = 1
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic [4:0]             in_req,
  input  logic [4:0][FLIT_W-1:0] in_flit,
  output logic [4:0]             in_ack,
  output logic [4:0]             out_req,
  output logic [4:0][FLIT_W-1:0] out_flit,
  input  logic [4:0]             out_ack
);
  localparam int TW = FLIT_W / 2;
  localparam int CW = TW / 2;

  logic [NP-1:0][FLIT_W-1:0] head;
  logic [NP-1:0]             empty, full, push, pop;
  logic [NP-1:0][2:0]        want;
  logic [NP-1:0]             req_vec, grant_vec;
  logic [NP-1:0]             out_busy, linked, xfer_out, xfer_in, done_pkt;
  logic [NP-1:0][2:0]        out_src, in_dst;
  logic [NP-1:0][FLIT_W-1:0] left;
  phase_e [NP-1:0]           phase;

  // R2: accept only while the queue has room
  assign in_ack = in_req & ~full;
  assign push   = in_req & in_ack;

  for (genvar g = 0; g < NP; g++) begin : g_q
    flit_fifo #(.W(FLIT_W), .DEPTH(QDEPTH)) q_i (
      .clk(clk), .rst_n(rst_n), .push(push[g]), .pop(pop[g]),
      .din(in_flit[g]), .dout(head[g]), .empty(empty[g]), .full(full[g])
    );
  end

  always_comb begin
    for (int i = 0; i < NP; i++) begin
      want[i]    = xy_route(8'(head[i][TW-1:CW]), 8'(head[i][CW-1:0]),
                            8'(MY_X), 8'(MY_Y));
      req_vec[i] = !empty[i] && !linked[i] && !out_busy[want[i]];
    end
  end

  rr_arb #(.N(NP)) arb_i (.clk(clk), .rst_n(rst_n), .req(req_vec), .grant(grant_vec));

  // R6 R8: an output shows the head of its connected queue
  always_comb begin
    for (int o = 0; o < NP; o++) begin
      out_req[o]  = out_busy[o] && !empty[out_src[o]];
      out_flit[o] = head[out_src[o]];
    end
    xfer_out = out_req & out_ack;
    for (int i = 0; i < NP; i++) begin
      xfer_in[i]  = linked[i] && xfer_out[in_dst[i]];
      // R7: release after the length flit (N=0) or the last payload flit
      done_pkt[i] = xfer_in[i] &&
                    ((phase[i] == PH_SIZE && head[i] == '0) ||
                     (phase[i] == PH_BODY && left[i] == FLIT_W'(1)));
    end
  end
  assign pop = xfer_in;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_busy <= '0;
      out_src  <= '0;
      linked   <= '0;
      in_dst   <= '0;
      left     <= '0;
      for (int i = 0; i < NP; i++) phase[i] <= PH_HEAD;
    end else begin
      for (int i = 0; i < NP; i++) begin
        if (grant_vec[i]) begin
          linked[i]         <= 1'b1;
          in_dst[i]         <= want[i];
          phase[i]          <= PH_HEAD;
          out_busy[want[i]] <= 1'b1;
          out_src[want[i]]  <= 3'(i);
        end
        if (xfer_in[i]) begin
          case (phase[i])
            PH_HEAD: phase[i] <= PH_SIZE;
            PH_SIZE: begin
              left[i]  <= head[i];
              phase[i] <= PH_BODY;
            end
            default: left[i] <= left[i] - 1'b1;
          endcase
        end
        if (done_pkt[i]) begin
          linked[i]           <= 1'b0;
          out_busy[in_dst[i]] <= 1'b0;
          phase[i]            <= PH_HEAD;
        end
      end
    end
  end
endmodule

// File: rtl/router_chk.sv
module router_chk #(
  parameter int FLIT_W = 16
) (
  input logic                   clk,
  input logic                   rst_n,
  input logic [4:0]             grant_vec,
  input logic [4:0]             req_vec,
  input logic [4:0]             out_req,
  input logic [4:0]             out_ack,
  input logic [4:0]             out_busy,
  input logic [4:0][FLIT_W-1:0] out_flit,
  input logic [4:0][2:0]        out_src
);
  logic [4:0][4:0] uses;
  always_comb begin
    for (int i = 0; i < 5; i++)
      for (int o = 0; o < 5; o++)
        uses[i][o] = out_busy[o] && (out_src[o] == 3'(i));
  end

  a_r10_single_grant: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(grant_vec));

  a_r9_grant_subset_req: assert property (@(posedge clk) disable iff (!rst_n)
    (grant_vec & ~req_vec) == 5'b0);

  for (genvar o = 0; o < 5; o++) begin : g_o
    a_r8_hold_flit: assert property (@(posedge clk) disable iff (!rst_n)
      (out_req[o] && !out_ack[o]) |=> (out_req[o] && $stable(out_flit[o])));
  end

  for (genvar i = 0; i < 5; i++) begin : g_i
    a_r6_single_path: assert property (@(posedge clk) disable iff (!rst_n)
      $countones(uses[i]) <= 1);
  end
endmodule

bind mesh_router router_chk #(.FLIT_W(FLIT_W)) chk_i (
  .clk(clk), .rst_n(rst_n), .grant_vec(grant_vec), .req_vec(req_vec),
  .out_req(out_req), .out_ack(out_ack), .out_busy(out_busy),
  .out_flit(out_flit), .out_src(out_src)
);

// File: tb/mesh_router_tb_top.sv
module mesh_router_tb_top;
  localparam int FW = 16, QD = 4, MX = 2, MY = 2;
  localparam int MAXP = 40, MAXF = 12;

  logic clk = 1'b0;
  always #10 clk = ~clk;
  logic rst_n;

  logic [4:0]         in_req, in_ack, out_req, out_ack;
  logic [4:0][FW-1:0] in_flit, out_flit;
  logic               rq [5];
  logic [FW-1:0]      fl [5];
  logic               oa [5];

  always_comb begin
    for (int p = 0; p < 5; p++) begin
      in_req[p]  = rq[p];
      in_flit[p] = fl[p];
      out_ack[p] = oa[p];
    end
  end

  mesh_router #(.FLIT_W(FW), .QDEPTH(QD), .MY_X(MX), .MY_Y(MY)) dut_i (
    .clk(clk), .rst_n(rst_n), .in_req(in_req), .in_flit(in_flit), .in_ack(in_ack),
    .out_req(out_req), .out_flit(out_flit), .out_ack(out_ack));

  // narrow build for R11
  logic [4:0]        b_req, b_ack, c_req;
  logic [4:0][7:0]   b_flit, c_flit;
  mesh_router #(.FLIT_W(8), .QDEPTH(2), .MY_X(1), .MY_Y(1)) dut8_i (
    .clk(clk), .rst_n(rst_n), .in_req(b_req), .in_flit(b_flit), .in_ack(b_ack),
    .out_req(c_req), .out_flit(c_flit), .out_ack(5'h1f));

  int checks = 0, fails = 0, cyc = 0;
  task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // packet store
  logic [FW-1:0] pf [MAXP][MAXF];
  int  plen [MAXP], pout [MAXP];
  bit  pdone [MAXP], pstart [MAXP];
  int  npk = 0;

  function automatic int ref_route(int x, int y);
    if (x != MX) return (x > MX) ? 0 : 1;
    if (y != MY) return (y > MY) ? 2 : 3;
    return 4;
  endfunction

  task automatic mk(input int x, input int y, input int size, output int pid);
    pid = npk;
    npk++;
    pf[pid][0] = {8'(pid), 4'(x), 4'(y)};
    pf[pid][1] = FW'(size);
    for (int k = 0; k < size; k++) pf[pid][k+2] = FW'(16'hA000 + pid * 16 + k);
    plen[pid] = size + 2;
    pout[pid] = ref_route(x, y);
  endtask

  int accepted [5];
  task automatic send(input int p, input int pid);
    for (int k = 0; k < plen[pid]; k++) begin
      @(negedge clk);
      rq[p] = 1'b1;
      fl[p] = pf[pid][k];
      #5;
      while (!in_ack[p]) begin
        @(negedge clk);
        #5;
      end
      accepted[p]++;
    end
    @(negedge clk);
    rq[p] = 1'b0;
  endtask

  int ids [5][3];
  task automatic send_three(input int p);
    for (int j = 0; j < 3; j++) send(p, ids[p][j]);
  endtask

  // downstream acknowledge pattern
  bit blk [5];
  bit stall;
  always @(posedge clk) cyc <= cyc + 1;
  always @(negedge clk)
    for (int o = 0; o < 5; o++)
      oa[o] = blk[o] ? 1'b0 : (stall ? (((cyc + 3 * o) % 4) != 0) : 1'b1);

  // per-clock reference comparison on the outputs
  int cur [5], idx [5], first_cyc [5], logn [5];
  int logv [5][16];
  bit prev_hold [5], prev_req [5];
  logic [FW-1:0] prev_flit [5];

  always begin
    @(negedge clk);
    #5;
    if (rst_n) begin
      for (int o = 0; o < 5; o++) begin
        if (prev_hold[o])
          chk(out_req[o] && out_flit[o] == prev_flit[o], "R8 hold", out_flit[o], prev_flit[o]);
        if (out_req[o] && !prev_req[o]) first_cyc[o] = cyc;
        if (out_req[o] && out_ack[o]) begin
          if (cur[o] < 0) begin
            int found;
            found = -1;
            for (int q = 0; q < npk; q++)
              if (found < 0 && !pstart[q] && pf[q][0] == out_flit[o]) found = q;
            if (found < 0) chk(1'b0, "R3 unknown header", out_flit[o], 0);
            else begin
              chk(pout[found] == o, (pout[found] == 4) ? "R5 local" : "R4 route", o, pout[found]);
              pstart[found] = 1'b1;
              cur[o] = found;
              idx[o] = 1;
              if (logn[o] < 16) logv[o][logn[o]] = found;
              logn[o]++;
            end
          end else begin
            chk(out_flit[o] == pf[cur[o]][idx[o]], "R6 wormhole order",
                out_flit[o], pf[cur[o]][idx[o]]);
            idx[o]++;
            if (idx[o] == plen[cur[o]]) begin
              pdone[cur[o]] = 1'b1;
              cur[o] = -1;
            end
          end
        end
        prev_hold[o] = out_req[o] && !out_ack[o];
        prev_flit[o] = out_flit[o];
        prev_req[o]  = out_req[o];
      end
    end
  end

  // narrow-instance monitor
  logic [7:0] got8 [8];
  int n8 = 0, other8 = 0;
  always begin
    @(negedge clk);
    #5;
    if (rst_n) begin
      if (c_req[3]) begin
        if (n8 < 8) got8[n8] = c_flit[3];
        n8++;
      end
      if (c_req[0] || c_req[1] || c_req[2] || c_req[4]) other8++;
    end
  end

  task automatic wait_done(input int a, input int b);
    while (!(pdone[a] && pdone[b])) @(negedge clk);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    checks++;
    fails++;
    $display("FAIL watchdog expired actual=%0d expected=%0d", cyc, 0);
    $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    int a, b, c, d, e;
    bit all;
    logic [7:0] exp8 [5];
    for (int p = 0; p < 5; p++) begin
      rq[p] = 0; fl[p] = '0; oa[p] = 1'b1; blk[p] = 0; cur[p] = -1; idx[p] = 0;
      logn[p] = 0; prev_hold[p] = 0; prev_req[p] = 0; prev_flit[p] = '0;
      first_cyc[p] = 0; accepted[p] = 0;
    end
    stall = 0;
    b_req = '0;
    b_flit = '0;
    rst_n = 1'b0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    #5;
    chk(out_req == 5'b0, "R1 reset outputs idle", out_req, 0);
    chk(in_ack == 5'b0 && c_req == 5'b0, "R1 reset no ack", in_ack, 0);
    rst_n = 1'b1;

    // R9: pointer starts at east; west beats north
    mk(2, 2, 2, a);
    mk(2, 2, 1, b);
    fork send(1, a); send(2, b); join
    wait_done(a, b);
    chk(logv[4][0] == a, "R9 first winner", logv[4][0], a);
    chk(logv[4][1] == b, "R9 second winner", logv[4][1], b);

    // R9: pointer now after north, so south beats north
    mk(2, 2, 1, c);
    mk(2, 2, 2, d);
    fork send(2, c); send(3, d); join
    wait_done(c, d);
    chk(logv[4][2] == d, "R9 rotated winner", logv[4][2], d);
    chk(logv[4][3] == c, "R9 rotated loser", logv[4][3], c);

    // R10: two free outputs open on consecutive cycles
    mk(0, 2, 1, a);
    mk(3, 2, 1, b);
    fork send(0, a); send(1, b); join
    wait_done(a, b);
    chk(first_cyc[0] - first_cyc[1] == 1, "R10 one grant per cycle",
        first_cyc[0] - first_cyc[1], 1);

    // R2: blocked east output fills the local queue
    blk[0] = 1;
    mk(3, 2, 8, e);
    fork send(4, e); join_none
    repeat (20) @(negedge clk);
    #5;
    chk(rq[4] && !in_ack[4], "R2 ack withheld when full", in_ack[4], 0);
    chk(accepted[4] == QD, "R2 queue depth", accepted[4], QD);
    blk[0] = 0;
    wait_done(e, e);

    // R7: zero-length packet releases, next packet follows
    mk(2, 3, 0, a);
    mk(2, 3, 1, b);
    fork send(3, a); send(0, b); join
    wait_done(a, b);
    repeat (3) @(negedge clk);
    #5;
    chk(out_req[2] == 1'b0, "R7 output idle after release", out_req[2], 0);

    // R3 R6: mixed traffic with stalled acknowledges
    stall = 1;
    for (int p = 0; p < 5; p++)
      for (int j = 0; j < 3; j++) begin
        int t, x, y;
        t = (p * 3 + j) % 5;
        x = (t == 0) ? 3 : (t == 1) ? 0 : 2;
        y = (t == 2) ? 3 : (t == 3) ? 0 : 2;
        mk(x, y, (p + j) % 4 + 1, ids[p][j]);
      end
    for (int p = 0; p < 5; p++) begin
      automatic int pp = p;
      fork send_three(pp); join_none
    end
    all = 0;
    while (!all) begin
      @(negedge clk);
      all = 1;
      for (int q = 0; q < npk; q++) if (!pdone[q]) all = 0;
    end
    stall = 0;
    for (int q = 0; q < npk; q++) chk(pdone[q], "R3 packet delivered", pdone[q], 1);

    // R11: 8-bit build, header 0x54 -> x=1,y=0 -> south
    exp8[0] = 8'h54; exp8[1] = 8'h03; exp8[2] = 8'h11; exp8[3] = 8'h22; exp8[4] = 8'h33;
    for (int k = 0; k < 5; k++) begin
      @(negedge clk);
      b_req[4] = 1'b1;
      b_flit[4] = exp8[k];
      #5;
      while (!b_ack[4]) begin
        @(negedge clk);
        #5;
      end
    end
    @(negedge clk);
    b_req[4] = 1'b0;
    repeat (6) @(negedge clk);
    chk(n8 == 5, "R11 narrow flit count", n8, 5);
    chk(other8 == 0, "R11 narrow wrong port", other8, 0);
    for (int k = 0; k < 5; k++)
      if (k < n8) chk(got8[k] == exp8[k], "R11 narrow flit", got8[k], exp8[k]);

    $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule